// File: doc/BRIEF.md
# Late-ALU Pipeline Hazard Unit

This block is the interlock and bypass controller for a five-stage in-order pipeline in which stage 3 holds only an address adder and the general ALU works in stage 4, next to the data memory. In stage 3 a load or store forms its address as base register plus sign-extended offset. Every other instruction carries its operands unchanged into stage 4, where the ALU runs. The ALU is idle for memory instructions, and the data memory is idle for ALU instructions. Branches and jumps are not handled.

The unit is purely combinational. It reads the source specifiers, destinations, write enables and class flags held in the pipeline registers in front of decode, execute, memory and write-back. It returns one stall line and six bypass selects, one for each operand in decode, execute and memory. On a stall the pipeline holds PC and IF/ID and sends a bubble into execute with all write enables cleared.

Moving the ALU to stage 4 changes where the pipeline must wait. A load followed by an ALU operation that uses the loaded value runs without waiting. A load or store whose base register is written by the instruction directly ahead of it must wait one cycle.

Top module: `late_alu_hazard_unit`

## Requirements
- R1: `stall` is 1 in the same cycle when decode holds a load or store, execute holds an ALU op or a load with its write enable set, and the execute destination equals the decode base register (`id_rs1`).
- R2: An ALU instruction in decode does not stall on an execute-stage producer of either operand. A store whose data register (`id_rs2`) alone matches does not stall either.
- R3: A producer in memory or write-back never causes a stall.
- R4: Register 0 never raises `stall` and never selects a bypass, even with a write enable set.
- R5: No stall occurs when the execute instruction has its write enable cleared, or is neither an ALU op nor a load.
- R6: Each memory-stage ALU operand select is 1 (take the write-back result) when the memory instruction is an ALU op and that source equals the write-back destination with its write enable set. Otherwise it is 0 (take the pipeline value).
- R7: Store data in the memory stage (`mem_fwd_b`) takes the write-back result on a match without stalling. A memory-stage load or store leaves `mem_fwd_a` at 0, because the ALU is idle.
- R8: An execute-stage select is 1 when its source matches the write-back destination. It stays 0 if the memory-stage destination also matches, because the nearest producer wins and that value is bypassed in stage 4.
- R9: With the decode bypass enabled (the default), a decode select is 1 on a write-back match. It stays 0 when a newer producer in execute or memory writes the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | Decode base / first source |
| id_rs2 | input | AW | Decode second source / store data |
| id_is_load | input | 1 | Decode instruction is a load |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | AW | Execute first source |
| ex_rs2 | input | AW | Execute second source |
| ex_rd | input | AW | Execute destination |
| ex_we | input | 1 | Execute write enable |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_alu | input | 1 | Execute instruction is an ALU op |
| mem_rs1 | input | AW | Memory-stage first source |
| mem_rs2 | input | AW | Memory-stage second source / store data |
| mem_rd | input | AW | Memory-stage destination |
| mem_we | input | 1 | Memory-stage write enable |
| mem_is_alu | input | 1 | Memory-stage instruction is an ALU op |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | AW | Write-back destination |
| wb_we | input | 1 | Write-back write enable |
| stall | output | 1 | Hold PC and IF/ID, bubble into execute |
| id_fwd_a | output | 1 | Decode operand A select (1 = write-back result) |
| id_fwd_b | output | 1 | Decode operand B select |
| ex_fwd_a | output | 1 | Adder / pass-through operand A select |
| ex_fwd_b | output | 1 | Pass-through operand B select |
| mem_fwd_a | output | 1 | ALU operand A select |
| mem_fwd_b | output | 1 | ALU operand B / store data select |

## Verification
Each input pattern places a producer at one distance from the consumer: execute, memory or write-back. The patterns then vary the consumer class (load, store, ALU) and the register matched (base or data), so the single stalling case is separated from its near neighbours that must not stall. Further patterns set competing producers in two stages at once, which separates nearest-first priority from plain matching. Other patterns use register 0 or cleared write enables to show that a matching specifier alone does nothing.

// File: rtl/lah_pkg.sv
package lah_pkg;
   // operand source choice for every bypass mux
   typedef enum logic {
      SRC_PIPE = 1'b0,
      SRC_WB   = 1'b1
   } src_e;
endpackage

// File: rtl/lah_base_stall.sv
module lah_base_stall #(
   parameter int AW = 5
) (
   input  logic          id_is_load,
   input  logic          id_is_store,
   input  logic [AW-1:0] id_base,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_we,
   input  logic          ex_is_load,
   input  logic          ex_is_alu,
   output logic          stall
);
   logic id_needs_addr;
   logic ex_late_result;
   logic base_live;

   // address is formed in stage 3, producers finish at end of stage 4
   assign id_needs_addr  = id_is_load | id_is_store;
   assign ex_late_result = ex_we & (ex_is_load | ex_is_alu);
   assign base_live      = |id_base;
   assign stall          = id_needs_addr & ex_late_result & base_live & (ex_rd == id_base);
endmodule

// File: rtl/lah_fwd_pick.sv
module lah_fwd_pick #(
   parameter int AW      = 5,
   parameter int N_NEWER = 0,
   localparam int NW     = (N_NEWER > 0) ? N_NEWER : 1
) (
   input  logic                en,
   input  logic [AW-1:0]       src,
   input  logic [AW-1:0]       wb_rd,
   input  logic                wb_we,
   input  logic [NW-1:0][AW-1:0] newer_rd,
   input  logic [NW-1:0]       newer_we,
   output logic                sel
);
   import lah_pkg::*;

   logic          src_live;
   logic          wb_hit;
   logic [NW-1:0] newer_hit;
   logic          shadowed;

   assign src_live = |src;
   assign wb_hit   = wb_we & (wb_rd == src);

   for (genvar i = 0; i < NW; i++) begin : g_newer
      assign newer_hit[i] = newer_we[i] & (newer_rd[i] == src);
   end

   // a newer writer of the same register supersedes the write-back value
   assign shadowed = (N_NEWER > 0) ? (|newer_hit) : 1'b0;

   always_comb begin
      sel = SRC_PIPE;
      if (en && src_live && wb_hit && !shadowed) sel = SRC_WB;
   end
endmodule

// File: rtl/late_alu_hazard_unit.sv
module late_alu_hazard_unit #(
   parameter int AW           = 5,
   parameter bit ID_WB_BYPASS = 1'b1
) (
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic          id_is_load,
   input  logic          id_is_store,
   input  logic [AW-1:0] ex_rs1,
   input  logic [AW-1:0] ex_rs2,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_we,
   input  logic          ex_is_load,
   input  logic          ex_is_alu,
   input  logic [AW-1:0] mem_rs1,
   input  logic [AW-1:0] mem_rs2,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_we,
   input  logic          mem_is_alu,
   input  logic          mem_is_store,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_we,
   output logic          stall,
   output logic          id_fwd_a,
   output logic          id_fwd_b,
   output logic          ex_fwd_a,
   output logic          ex_fwd_b,
   output logic          mem_fwd_a,
   output logic          mem_fwd_b
);
   import lah_pkg::*;

   localparam int NREGS = 1 << AW;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("late_alu_hazard_unit: AW must lie in 1..8");
   end
   if (NREGS < 2) begin : g_bad_nregs
      $error("late_alu_hazard_unit: need at least two registers");
   end

   // execute destination and memory destination as newer-producer lists
   logic [1:0][AW-1:0] id_newer_rd;
   logic [1:0]         id_newer_we;
   logic [0:0][AW-1:0] ex_newer_rd;
   logic [0:0]         ex_newer_we;
   logic [0:0][AW-1:0] mem_newer_rd;
   logic [0:0]         mem_newer_we;

   assign id_newer_rd  = {mem_rd, ex_rd};
   assign id_newer_we  = {mem_we, ex_we};
   assign ex_newer_rd  = mem_rd;
   assign ex_newer_we  = mem_we;
   assign mem_newer_rd = '0;
   assign mem_newer_we = '0;

   lah_base_stall #(.AW(AW)) u_stall (
      .id_is_load (id_is_load),
      .id_is_store(id_is_store),
      .id_base    (id_rs1),
      .ex_rd      (ex_rd),
      .ex_we      (ex_we),
      .ex_is_load (ex_is_load),
      .ex_is_alu  (ex_is_alu),
      .stall      (stall)
   );

   // decode bypass: optional, a write-first register file makes it redundant
   if (ID_WB_BYPASS) begin : g_id_bypass
      lah_fwd_pick #(.AW(AW), .N_NEWER(2)) u_id_a (
         .en(1'b1), .src(id_rs1), .wb_rd(wb_rd), .wb_we(wb_we),
         .newer_rd(id_newer_rd), .newer_we(id_newer_we), .sel(id_fwd_a)
      );
      lah_fwd_pick #(.AW(AW), .N_NEWER(2)) u_id_b (
         .en(1'b1), .src(id_rs2), .wb_rd(wb_rd), .wb_we(wb_we),
         .newer_rd(id_newer_rd), .newer_we(id_newer_we), .sel(id_fwd_b)
      );
   end else begin : g_id_plain
      assign id_fwd_a = SRC_PIPE;
      assign id_fwd_b = SRC_PIPE;
   end

   // stage 3: adder base and pass-through operands
   lah_fwd_pick #(.AW(AW), .N_NEWER(1)) u_ex_a (
      .en(1'b1), .src(ex_rs1), .wb_rd(wb_rd), .wb_we(wb_we),
      .newer_rd(ex_newer_rd), .newer_we(ex_newer_we), .sel(ex_fwd_a)
   );
   lah_fwd_pick #(.AW(AW), .N_NEWER(1)) u_ex_b (
      .en(1'b1), .src(ex_rs2), .wb_rd(wb_rd), .wb_we(wb_we),
      .newer_rd(ex_newer_rd), .newer_we(ex_newer_we), .sel(ex_fwd_b)
   );

   // stage 4: ALU operands, store data on the second port
   lah_fwd_pick #(.AW(AW), .N_NEWER(0)) u_mem_a (
      .en(mem_is_alu), .src(mem_rs1), .wb_rd(wb_rd), .wb_we(wb_we),
      .newer_rd(mem_newer_rd), .newer_we(mem_newer_we), .sel(mem_fwd_a)
   );
   lah_fwd_pick #(.AW(AW), .N_NEWER(0)) u_mem_b (
      .en(mem_is_alu | mem_is_store), .src(mem_rs2), .wb_rd(wb_rd), .wb_we(wb_we),
      .newer_rd(mem_newer_rd), .newer_we(mem_newer_we), .sel(mem_fwd_b)
   );
endmodule

// File: rtl/lah_checker.sv
module lah_checker #(
   parameter int AW = 5
) (
   input logic [AW-1:0] id_rs1,
   input logic [AW-1:0] id_rs2,
   input logic          id_is_load,
   input logic          id_is_store,
   input logic [AW-1:0] ex_rs1,
   input logic [AW-1:0] ex_rd,
   input logic          ex_we,
   input logic          ex_is_load,
   input logic          ex_is_alu,
   input logic [AW-1:0] mem_rd,
   input logic          mem_we,
   input logic          mem_is_alu,
   input logic          mem_is_store,
   input logic          wb_we,
   input logic          stall,
   input logic          id_fwd_a,
   input logic          id_fwd_b,
   input logic          ex_fwd_a,
   input logic          mem_fwd_a,
   input logic          mem_fwd_b
);
   always_comb begin
      AST_STALL_NEEDS_MEM_OP: assert (!stall || id_is_load || id_is_store)
         else $error("stall without memory op in decode"); // R2
      AST_STALL_NEEDS_LATE_PRODUCER: assert (!stall || (ex_we && (ex_is_alu || ex_is_load)))
         else $error("stall without late producer"); // R5
      AST_STALL_BASE_NONZERO: assert (!stall || (id_rs1 != '0 && ex_rd == id_rs1))
         else $error("stall on zero or unmatched base"); // R4
      AST_ZERO_NO_FWD: assert ((id_rs1 != '0 || !id_fwd_a) && (id_rs2 != '0 || !id_fwd_b))
         else $error("register 0 bypassed"); // R4
      AST_MEM_IDLE_ALU: assert (mem_is_alu || !mem_fwd_a)
         else $error("ALU operand bypass while ALU idle"); // R7
      AST_MEM_B_CLASS: assert (mem_is_alu || mem_is_store || !mem_fwd_b)
         else $error("second operand bypass with no consumer"); // R6
      AST_EX_NEAREST: assert (!(mem_we && mem_rd != '0 && mem_rd == ex_rs1) || !ex_fwd_a)
         else $error("older value chosen over memory producer"); // R8
      AST_FWD_NEEDS_WB: assert (wb_we || !(id_fwd_a || ex_fwd_a || mem_fwd_a || mem_fwd_b))
         else $error("bypass without write-back"); // R6
   end
endmodule

bind late_alu_hazard_unit lah_checker #(.AW(AW)) u_lah_checker (
   .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_load(id_is_load), .id_is_store(id_is_store),
   .ex_rs1(ex_rs1), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
   .ex_is_alu(ex_is_alu), .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_alu(mem_is_alu),
   .mem_is_store(mem_is_store), .wb_we(wb_we), .stall(stall), .id_fwd_a(id_fwd_a),
   .id_fwd_b(id_fwd_b), .ex_fwd_a(ex_fwd_a), .mem_fwd_a(mem_fwd_a), .mem_fwd_b(mem_fwd_b)
);

// File: tb/tb_late_alu_hazard_unit.sv
module tb_late_alu_hazard_unit;
   localparam int AW = 5;

   typedef struct {
      logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs1, mem_rs2, mem_rd, wb_rd;
      logic id_is_load, id_is_store, ex_we, ex_is_load, ex_is_alu;
      logic mem_we, mem_is_alu, mem_is_store, wb_we;
   } stim_t;

   typedef struct {
      logic       stall;
      logic [5:0] sel;   // {id_a, id_b, ex_a, ex_b, mem_a, mem_b}
      string      req;
   } exp_t;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   stim_t s;
   logic stall, id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b, mem_fwd_a, mem_fwd_b;
   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   late_alu_hazard_unit #(.AW(AW)) dut (
      .id_rs1(s.id_rs1), .id_rs2(s.id_rs2), .id_is_load(s.id_is_load),
      .id_is_store(s.id_is_store), .ex_rs1(s.ex_rs1), .ex_rs2(s.ex_rs2),
      .ex_rd(s.ex_rd), .ex_we(s.ex_we), .ex_is_load(s.ex_is_load),
      .ex_is_alu(s.ex_is_alu), .mem_rs1(s.mem_rs1), .mem_rs2(s.mem_rs2),
      .mem_rd(s.mem_rd), .mem_we(s.mem_we), .mem_is_alu(s.mem_is_alu),
      .mem_is_store(s.mem_is_store), .wb_rd(s.wb_rd), .wb_we(s.wb_we),
      .stall(stall), .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
      .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
      .mem_fwd_a(mem_fwd_a), .mem_fwd_b(mem_fwd_b)
   );

   function automatic stim_t idle();
      stim_t t;
      t.id_rs1 = '0; t.id_rs2 = '0; t.ex_rs1 = '0; t.ex_rs2 = '0; t.ex_rd = '0;
      t.mem_rs1 = '0; t.mem_rs2 = '0; t.mem_rd = '0; t.wb_rd = '0;
      t.id_is_load = 0; t.id_is_store = 0; t.ex_we = 0; t.ex_is_load = 0;
      t.ex_is_alu = 0; t.mem_we = 0; t.mem_is_alu = 0; t.mem_is_store = 0; t.wb_we = 0;
      return t;
   endfunction

   // driver: apply one pattern at a rising edge, queue what must appear
   task automatic drive(input stim_t t, input logic es, input logic [5:0] esel, input string req);
      exp_t e;
      @(posedge clk);
      #1;
      s = t;
      e.stall = es; e.sel = esel; e.req = req;
      q.push_back(e);
   endtask

   // monitor: compare at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         logic [5:0] got;
         e   = q.pop_front();
         got = {id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b, mem_fwd_a, mem_fwd_b};
         checks++;
         if (stall !== e.stall) begin
            errors++;
            $display("FAIL %s stall actual=%b expected=%b", e.req, stall, e.stall);
         end
         checks++;
         if (got !== e.sel) begin
            errors++;
            $display("FAIL %s selects actual=%b expected=%b", e.req, got, e.sel);
         end
      end
   end

   initial begin
      stim_t t;
      s = idle();
      repeat (2) @(posedge clk);

      // reset / idle state: nothing stalls, nothing bypasses
      drive(idle(), 1'b0, 6'b000000, "R4 idle");

      // R1: load base written by ALU op in execute
      t = idle(); t.id_is_load = 1; t.id_rs1 = 5; t.ex_is_alu = 1; t.ex_we = 1; t.ex_rd = 5;
      drive(t, 1'b1, 6'b000000, "R1 alu->load base");
      // R1: store base written by load in execute
      t = idle(); t.id_is_store = 1; t.id_rs1 = 7; t.ex_is_load = 1; t.ex_we = 1; t.ex_rd = 7;
      drive(t, 1'b1, 6'b000000, "R1 load->store base");
      // R2: ALU consumer of load result, both operands
      t = idle(); t.id_rs1 = 5; t.id_rs2 = 5; t.ex_is_load = 1; t.ex_we = 1; t.ex_rd = 5;
      drive(t, 1'b0, 6'b000000, "R2 load->alu");
      // R2: store data matches, base does not
      t = idle(); t.id_is_store = 1; t.id_rs1 = 3; t.id_rs2 = 5; t.ex_is_alu = 1; t.ex_we = 1; t.ex_rd = 5;
      drive(t, 1'b0, 6'b000000, "R2 store data");
      // R3: producer two ahead
      t = idle(); t.id_is_load = 1; t.id_rs1 = 5; t.mem_is_alu = 1; t.mem_we = 1; t.mem_rd = 5;
      drive(t, 1'b0, 6'b000000, "R3 distance two");
      // R5: write enable cleared
      t = idle(); t.id_is_load = 1; t.id_rs1 = 5; t.ex_is_alu = 1; t.ex_we = 0; t.ex_rd = 5;
      drive(t, 1'b0, 6'b000000, "R5 no write");
      // R5: execute instruction neither ALU nor load
      t = idle(); t.id_is_store = 1; t.id_rs1 = 5; t.ex_we = 1; t.ex_rd = 5;
      drive(t, 1'b0, 6'b000000, "R5 other class");
      // R4: register 0 everywhere with write enables set
      t = idle(); t.id_is_load = 1; t.ex_is_alu = 1; t.ex_we = 1; t.mem_is_alu = 1;
      t.mem_we = 1; t.wb_we = 1;
      drive(t, 1'b0, 6'b000000, "R4 zero register");
      // R6: ALU operands from write-back
      t = idle(); t.mem_is_alu = 1; t.mem_rs1 = 9; t.mem_rs2 = 9; t.wb_we = 1; t.wb_rd = 9;
      drive(t, 1'b0, 6'b000011, "R6 alu bypass");
      t.wb_we = 0;
      drive(t, 1'b0, 6'b000000, "R6 no write-back");
      // R7: store data bypass, base untouched
      t = idle(); t.mem_is_store = 1; t.mem_rs1 = 4; t.mem_rs2 = 4; t.wb_we = 1; t.wb_rd = 4;
      drive(t, 1'b0, 6'b000001, "R7 store data");
      // R7: load in memory stage, ALU idle
      t.mem_is_store = 0;
      drive(t, 1'b0, 6'b000000, "R7 load idle alu");
      // R8: execute operands from write-back
      t = idle(); t.ex_rs1 = 6; t.ex_rs2 = 6; t.wb_we = 1; t.wb_rd = 6;
      drive(t, 1'b0, 6'b001100, "R8 ex bypass");
      t.mem_we = 1; t.mem_rd = 6;
      drive(t, 1'b0, 6'b000000, "R8 nearest wins");
      // R9: decode bypass and its suppression
      t = idle(); t.id_rs1 = 8; t.id_rs2 = 8; t.wb_we = 1; t.wb_rd = 8;
      drive(t, 1'b0, 6'b110000, "R9 id bypass");
      t.ex_is_alu = 1; t.ex_we = 1; t.ex_rd = 8;
      drive(t, 1'b0, 6'b000000, "R9 newer in ex");

      wait (q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule